// File: doc/BRIEF.md
# DRAM Controller Event Counter Bank

This block gathers performance statistics for a DRAM controller. Eight general counters each choose which controller events to count through a bitmap held in their own configuration register. Two further counters, one for DRAM reads and one for DRAM writes, count dedicated strobes. Software reaches every counter through a simple 64-bit register port that has a byte address, a write strobe and a combinational read path.

A general counter counts only after software puts it into manual mode and writes a start command. Counting stops when software writes an end command. The counter keeps its value for readout, and a per-counter status flag shows that the run has finished. No counter wraps: each one stops at its all-ones value. The two fixed counters have an enable register and a separate clear register.

Top module: `ddr_perf_bank`

## Requirements
- R1: After reset every counter value, configuration, mode, status and fixed-counter enable reads as zero.
- R2: In each cycle, a running and enabled general counter adds the number of event strobes that are high and selected by bits [62:0] of its configuration. An event with identifier N selects bit N-1 alone. A multi-increment event with identifier N selects the 4-bit field 0xF shifted left by N-1, so it can add up to four in one cycle.
- R3: Bit 63 of a general counter's configuration is its event enable. While that bit is clear, the counter ignores all event strobes.
- R4: Bit 0 of a counter's mode register selects manual mode. A start command to a counter that is not in manual mode has no effect.
- R5: Writing a value with bit 0 set to a manual-mode counter's start register clears the counter to zero, starts it and clears its status flag. An event in that same cycle is not counted.
- R6: Writing a value with bit 0 set to a counter's end register stops the counter and sets bit 0 of its status register. The value then holds, and an event in the cycle of the end write is not counted.
- R7: A general counter or fixed counter that reaches its all-ones maximum stays there and never wraps. An add that would pass the maximum clamps to it.
- R8: In the fixed control register, bit 0 enables the write counter on the write strobe and bit 1 enables the read counter on the read strobe. Each strobe adds one.
- R9: Writing the fixed clear register zeroes the write counter when bit 0 is set and the read counter when bit 1 is set. A clear wins over a strobe in the same cycle.
- R10: The block bases are: mode 0x20020, start 0x200A0, end 0x200E0, status 0x20120, configuration 0x20160, value 0x201C0. Counter i sits at base + 8*i. The fixed registers are control 0x20240, clear 0x20248, write value 0x20250 and read value 0x20258. Start, end, clear and unmapped addresses read as zero. Writes to value registers, status registers or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, same cycle |
| ev_pulse | input | EV_W | Single-cycle event strobes from the controller |
| dram_rd_pulse | input | 1 | DRAM read strobe for the fixed read counter |
| dram_wr_pulse | input | 1 | DRAM write strobe for the fixed write counter |

## Verification
A wrong bitmap or enable shows up at the next value read as a count that is off by the popcount of the strobes that were missed or counted in error. A start, end or mode fault shows up one cycle after the control write, either as a nonzero value after a start or as a value that keeps moving after an end. A saturation fault shows up as a small value on the cycle after the counter passes its maximum. Because the bench uses a narrow counter width, that happens within about twenty cycles. Every bench cycle reads back one register and compares it with a behavioural model, so each fault shows up within a cycle of the stimulus that exposes it.

// File: rtl/ddr_perf_bank.sv
`timescale 1ns/1ps
module ddr_perf_bank #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 64,
  parameter int EV_W    = 63,
  parameter int ADDR_W  = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic [EV_W-1:0]   ev_pulse,
  input  logic              dram_rd_pulse,
  input  logic              dram_wr_pulse
);
  localparam int A_MODE  = 32'h20020;
  localparam int A_START = 32'h200A0;
  localparam int A_END   = 32'h200E0;
  localparam int A_STAT  = 32'h20120;
  localparam int A_CFG   = 32'h20160;
  localparam int A_VAL   = 32'h201C0;
  localparam int A_FCTL  = 32'h20240;
  localparam int A_FCLR  = 32'h20248;
  localparam int A_FWV   = 32'h20250;
  localparam int A_FRV   = 32'h20258;
  localparam int INC_W   = $clog2(EV_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [NUM_CNT];
  logic [EV_W:0]    cfg_q [NUM_CNT];
  logic             run_q [NUM_CNT];
  logic             done_q[NUM_CNT];
  logic             man_q [NUM_CNT];
  logic             st_go [NUM_CNT];

  logic             fx_wen, fx_ren;
  logic [CNT_W-1:0] fx_wcnt, fx_rcnt;

  wire wr_fctl = reg_we && reg_addr == ADDR_W'(A_FCTL);
  wire wr_fclr = reg_we && reg_addr == ADDR_W'(A_FCLR);

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    wire wr_mode = reg_we && reg_addr == ADDR_W'(A_MODE + 8*i);
    wire wr_cfg  = reg_we && reg_addr == ADDR_W'(A_CFG + 8*i);
    wire wr_end  = reg_we && reg_addr == ADDR_W'(A_END + 8*i) && reg_wdata[0];
    assign st_go[i] = reg_we && reg_addr == ADDR_W'(A_START + 8*i) && reg_wdata[0] && man_q[i];

    wire [INC_W-1:0] inc = INC_W'($countones(ev_pulse & cfg_q[i][EV_W-1:0]));
    wire [CNT_W:0]   sum = {1'b0, cnt_q[i]} + (CNT_W+1)'(inc);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[i] <= '0; cfg_q[i] <= '0; run_q[i] <= 1'b0;
        done_q[i] <= 1'b0; man_q[i] <= 1'b0;
      end else begin
        if (wr_mode) man_q[i] <= reg_wdata[0];
        if (wr_cfg)  cfg_q[i] <= reg_wdata[EV_W:0];
        if (st_go[i]) begin
          cnt_q[i] <= '0; run_q[i] <= 1'b1; done_q[i] <= 1'b0;
        end else if (wr_end) begin
          run_q[i] <= 1'b0; done_q[i] <= 1'b1;
        end else if (run_q[i] && cfg_q[i][EV_W]) begin
          cnt_q[i] <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
        end
      end
    end

    // R5
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_go[i] |=> cnt_q[i] == '0);
    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[i] == CNT_MAX && !st_go[i]) |=> cnt_q[i] == CNT_MAX);
    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q[i] && !st_go[i]) |=> $stable(cnt_q[i]));
    // R3
    dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q[i][EV_W] && !st_go[i]) |=> $stable(cnt_q[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fx_wen <= 1'b0; fx_ren <= 1'b0; fx_wcnt <= '0; fx_rcnt <= '0;
    end else begin
      if (wr_fctl) begin
        fx_wen <= reg_wdata[0]; fx_ren <= reg_wdata[1];
      end
      if (wr_fclr && reg_wdata[0]) fx_wcnt <= '0;
      else if (fx_wen && dram_wr_pulse && fx_wcnt != CNT_MAX) fx_wcnt <= fx_wcnt + 1'b1;
      if (wr_fclr && reg_wdata[1]) fx_rcnt <= '0;
      else if (fx_ren && dram_rd_pulse && fx_rcnt != CNT_MAX) fx_rcnt <= fx_rcnt + 1'b1;
    end
  end

  // R9
  fclr_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fclr && reg_wdata[1]) |=> fx_rcnt == '0);
  // R9
  fclr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fclr && reg_wdata[0]) |=> fx_wcnt == '0);
  // R7
  fx_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fx_rcnt == CNT_MAX && !wr_fclr) |=> fx_rcnt == CNT_MAX);

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (reg_addr == ADDR_W'(A_MODE + 8*k)) reg_rdata = {63'b0, man_q[k]};
      if (reg_addr == ADDR_W'(A_STAT + 8*k)) reg_rdata = {63'b0, done_q[k]};
      if (reg_addr == ADDR_W'(A_CFG + 8*k))  reg_rdata = 64'(cfg_q[k]);
      if (reg_addr == ADDR_W'(A_VAL + 8*k))  reg_rdata = 64'(cnt_q[k]);
    end
    if (reg_addr == ADDR_W'(A_FCTL)) reg_rdata = {62'b0, fx_ren, fx_wen};
    if (reg_addr == ADDR_W'(A_FWV))  reg_rdata = 64'(fx_wcnt);
    if (reg_addr == ADDR_W'(A_FRV))  reg_rdata = 64'(fx_rcnt);
  end
endmodule

// File: tb/sim_ddr_perf_bank.sv
`timescale 1ns/1ps
module sim_ddr_perf_bank;
  localparam int CW = 10;
  localparam longint MAXV = (64'd1 << CW) - 1;
  localparam int M = 'h20020, ST = 'h200A0, EN = 'h200E0, SS = 'h20120, CF = 'h20160;
  localparam int VA = 'h201C0, FC = 'h20240, FL = 'h20248, FW = 'h20250, FR = 'h20258;

  logic clk = 0, rst_n = 0, reg_we = 0, rd_p = 0, wr_p = 0;
  logic [17:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic [62:0] ev = '0;
  always #5 clk = ~clk;

  ddr_perf_bank #(.CNT_W(CW)) u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pulse(ev), .dram_rd_pulse(rd_p),
    .dram_wr_pulse(wr_p));

  int nchk = 0, nerr = 0;
  longint m_cnt[8]; bit m_run[8], m_done[8], m_man[8]; logic [63:0] m_cfg[8];
  bit m_fw, m_fr; longint m_w, m_r;
  bit d_we, d_rs, d_ws; int d_a; logic [63:0] d_wd; logic [62:0] d_ev;

  function automatic int popc(logic [62:0] v);
    int n = 0;
    for (int b = 0; b < 63; b++) n += v[b];
    return n;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_cnt[i] = 0; m_run[i] = 0; m_done[i] = 0; m_man[i] = 0; m_cfg[i] = '0;
    end
    m_fw = 0; m_fr = 0; m_w = 0; m_r = 0;
  endtask

  task automatic model_step();
    bit ow = m_fw, orr = m_fr;
    for (int i = 0; i < 8; i++) begin
      bit oman = m_man[i]; logic [63:0] ocfg = m_cfg[i];
      if (d_we && d_a == M + 8*i)  m_man[i] = d_wd[0];
      if (d_we && d_a == CF + 8*i) m_cfg[i] = d_wd;
      if (d_we && d_a == ST + 8*i && d_wd[0] && oman) begin
        m_cnt[i] = 0; m_run[i] = 1; m_done[i] = 0;
      end else if (d_we && d_a == EN + 8*i && d_wd[0]) begin
        m_run[i] = 0; m_done[i] = 1;
      end else if (m_run[i] && ocfg[63]) begin
        m_cnt[i] += popc(d_ev & ocfg[62:0]);
        if (m_cnt[i] > MAXV) m_cnt[i] = MAXV;
      end
    end
    if (d_we && d_a == FC) begin m_fw = d_wd[0]; m_fr = d_wd[1]; end
    if (d_we && d_a == FL && d_wd[0]) m_w = 0;
    else if (ow && d_ws && m_w < MAXV) m_w++;
    if (d_we && d_a == FL && d_wd[1]) m_r = 0;
    else if (orr && d_rs && m_r < MAXV) m_r++;
  endtask

  function automatic logic [63:0] model_rd(int a);
    for (int i = 0; i < 8; i++) begin
      if (a == M + 8*i)  return 64'(m_man[i]);
      if (a == SS + 8*i) return 64'(m_done[i]);
      if (a == CF + 8*i) return m_cfg[i];
      if (a == VA + 8*i) return 64'(m_cnt[i]);
    end
    if (a == FC) return {62'b0, m_fr, m_fw};
    if (a == FW) return 64'(m_w);
    if (a == FR) return 64'(m_r);
    return 64'd0;
  endfunction

  task automatic check(int pa, string tag);
    logic [63:0] e = model_rd(pa);
    nchk++;
    if (reg_rdata !== e) begin
      nerr++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, pa, reg_rdata, e);
    end
  endtask

  task automatic cyc(bit we, int a, logic [63:0] wd, logic [62:0] e, bit rs, bit ws, int pa, string tag);
    @(negedge clk);
    reg_we = we; reg_addr = a[17:0]; reg_wdata = wd; ev = e; rd_p = rs; wr_p = ws;
    d_we = we; d_a = a; d_wd = wd; d_ev = e; d_rs = rs; d_ws = ws;
    @(posedge clk);
    model_step();
    #1; reg_we = 0; ev = '0; rd_p = 0; wr_p = 0; reg_addr = pa[17:0];
    #1; check(pa, tag);
  endtask

  task automatic wr(int a, logic [63:0] wd, int pa, string tag);
    cyc(1, a, wd, '0, 0, 0, pa, tag);
  endtask
  task automatic evc(logic [62:0] e, bit rs, bit ws, int pa, string tag);
    cyc(0, 0, 0, e, rs, ws, pa, tag);
  endtask

  initial begin
    #3_000_000;
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    foreach (m_cnt[i]) begin
      reg_addr = 18'(VA + 8*i); #1; check(VA + 8*i, "R1");
      reg_addr = 18'(CF + 8*i); #1; check(CF + 8*i, "R1");
      reg_addr = 18'(M + 8*i);  #1; check(M + 8*i, "R1");
    end
    reg_addr = 18'(FC); #1; check(FC, "R1");
    reg_addr = 18'(FR); #1; check(FR, "R1");

    // R2 single-bit event id 5 -> bit 4
    wr(M, 1, M, "R4");
    wr(CF, (64'd1 << 63) | (64'd1 << 4), CF, "R2");
    wr(ST, 1, VA, "R5");
    evc(63'h10, 0, 0, VA, "R2");
    evc(63'h13, 0, 0, VA, "R2");
    evc(63'h0f, 0, 0, VA, "R2");
    evc(63'h10, 0, 0, VA, "R2");
    // R2 four-bit field, event id 9 -> 0xF<<8
    wr(M + 8, 1, M + 8, "R4");
    wr(CF + 8, (64'd1 << 63) | (64'hF << 8), CF + 8, "R2");
    wr(ST + 8, 1, VA + 8, "R5");
    evc(63'h700, 0, 0, VA + 8, "R2");
    evc(63'hF00, 0, 0, VA + 8, "R2");
    evc(63'h1100, 0, 0, VA + 8, "R2");
    // R3 enable clear
    wr(M + 16, 1, M + 16, "R3");
    wr(CF + 16, 64'h3F, CF + 16, "R3");
    wr(ST + 16, 1, VA + 16, "R3");
    evc(63'h3F, 0, 0, VA + 16, "R3");
    evc(63'h3F, 0, 0, VA + 16, "R3");
    wr(CF + 16, (64'd1 << 63) | 64'h3F, VA + 16, "R3");
    evc(63'h3F, 0, 0, VA + 16, "R3");
    // R4 start without manual mode ignored
    wr(CF + 24, (64'd1 << 63) | 64'h1, CF + 24, "R4");
    wr(ST + 24, 1, VA + 24, "R4");
    evc(63'h1, 0, 0, VA + 24, "R4");
    evc(63'h1, 0, 0, VA + 24, "R4");
    // R5 restart with simultaneous event
    cyc(1, ST, 1, 63'h10, 0, 0, VA, "R5");
    evc(63'h10, 0, 0, VA, "R5");
    wr(ST, 0, VA, "R5");
    // R6 end with simultaneous event, hold, status
    cyc(1, EN + 8, 1, 63'hF00, 0, 0, VA + 8, "R6");
    evc(63'hF00, 0, 0, VA + 8, "R6");
    evc(63'hF00, 0, 0, SS + 8, "R6");
    wr(ST + 8, 1, SS + 8, "R6");
    evc(63'h100, 0, 0, VA + 8, "R6");
    // R7 saturation
    wr(M + 32, 1, M + 32, "R7");
    wr(CF + 32, '1, CF + 32, "R7");
    wr(ST + 32, 1, VA + 32, "R7");
    for (int k = 0; k < 20; k++) evc('1, 0, 0, VA + 32, "R7");
    evc('1, 0, 0, VA + 32, "R7");
    // R8 fixed counters
    evc(0, 1, 1, FR, "R8");
    wr(FC, 64'h1, FC, "R8");
    evc(0, 1, 1, FW, "R8");
    evc(0, 1, 1, FR, "R8");
    wr(FC, 64'h3, FC, "R8");
    for (int k = 0; k < 4; k++) evc(0, 1, 1, FR, "R8");
    evc(0, 1, 0, FW, "R8");
    for (int k = 0; k < 1030; k++) evc(0, 1, 0, FR, "R7");
    // R9 clear with simultaneous strobes
    cyc(1, FL, 64'h2, 0, 1, 1, FR, "R9");
    evc(0, 0, 0, FW, "R9");
    cyc(1, FL, 64'h1, 0, 1, 1, FW, "R9");
    evc(0, 1, 1, FR, "R9");
    // R10 map and ignored writes
    wr(VA, 64'h55, VA, "R10");
    wr(SS, 64'h0, SS, "R10");
    wr(FW, 64'h7, FW, "R10");
    wr('h20000, 64'hFF, 'h20000, "R10");
    wr(CF + 64, 64'hFF, CF + 64, "R10");
    wr(CF + 4, 64'hFF, CF + 4, "R10");
    evc(0, 0, 0, ST, "R10");
    evc(0, 0, 0, FL, "R10");
    for (int i = 0; i < 8; i++) evc(0, 0, 0, CF + 8*i, "R10");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule